// File: doc/BRIEF.md
# Backplane-Referenced LCD Digit Capture

This block listens to the drive lines of a four-digit, direct-drive seven-segment LCD that has one common backplane. Every line keeps toggling, so a segment's state lies in its phase. A segment that moves opposite to the backplane is lit. A segment that moves with the backplane is dark. The block passes all lines through two-flop synchronizers and finds each edge of the backplane. It then waits a fixed number of clocks so that skewed segment edges can settle, and only then takes a sample. It takes the lit pattern as each segment XOR the backplane, and decodes each digit to a BCD nibble.

The four nibbles form a 16-bit word. A latch pulse copies the word into a shift register, together with a flag that says whether every digit was a real numeral. The shift control then clocks the word out one bit per cycle, most significant digit first. A serial input fills the register from the bottom, so several of these blocks can be chained. All inputs are assumed to be logic-level signals already.

Top module: `lcd_seg_capture`

## Requirements
- R1: The lit pattern is each synchronized segment line XOR the synchronized backplane. A digit held on the glass decodes to the same value whether the sample falls in the backplane-low phase or the backplane-high phase.
- R2: The sampled word updates only at the end of a settle delay (`SETTLE_CYC` clocks, default 8) that starts at a synchronized backplane edge. No sample is ever taken in an edge cycle. A change of segment lines with no backplane edge is never captured.
- R3: Digit i uses `seg_in[7*i+6 : 7*i]`, with bit 6 = top, 5 = upper right, 4 = lower right, 3 = bottom, 2 = lower left, 1 = upper left, 0 = middle. The patterns for 0..9 are 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F and 7B in hex. In this font, 6 includes the top bar and 9 includes the bottom bar.
- R4: Any lit pattern other than the ten numerals, including letter glyphs and a blank digit, gives nibble 0xF for that digit and clears the word's valid flag.
- R5: Digit 3 occupies word bits 15:12 and digit 0 occupies bits 3:0.
- R6: When no shift is pending, a latch pulse copies the sampled word into the shift register and its valid flag onto `word_valid`.
- R7: Each clock with `shift_en` high moves the register up by one bit. `ser_out` shows bit 15, so the word leaves MSB first. `ser_in` enters at bit 0.
- R8: A latch pulse that arrives while a shift of a latched word is incomplete (fewer than 16 shifts since that latch) is ignored. The shift continues and still delivers the old word.
- R9: After reset, `ser_out` and `word_valid` are 0. A latch taken before any sample delivers 0xFFFF with `word_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_in | input | 28 | Raw segment drive lines, seven per digit |
| bp_in | input | 1 | Raw backplane drive line |
| latch_req | input | 1 | Copy the sampled word into the shift register |
| shift_en | input | 1 | Shift the register by one bit this clock |
| ser_in | input | 1 | Serial input for chaining |
| ser_out | output | 1 | Serial output, MSB of the register |
| word_valid | output | 1 | Every digit of the latched word was a numeral |

## Verification
On every cycle the assertions check four things. No sample lands on a backplane edge. The sampled word holds between strobes. A valid word never carries a nibble above 9, and an invalid word always carries a 0xF nibble. A latch loads the sampled word, each shift moves the register by exactly one bit with `ser_in` at the bottom, and a blocked latch leaves the register untouched. Only the bench scenarios can show the rest: the font mapping, the equal decode in both backplane phases, that a pattern change with no edge is never captured, that a latch soon after an edge still returns the earlier word, and the serial order seen at the pin.

// File: rtl/lcd_seg_capture.sv
module lcd_seg_capture #(
  parameter int DIGITS     = 4,
  parameter int SETTLE_CYC = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7*DIGITS-1:0]   seg_in,
  input  logic                  bp_in,
  input  logic                  latch_req,
  input  logic                  shift_en,
  input  logic                  ser_in,
  output logic                  ser_out,
  output logic                  word_valid
);
  localparam int SEG_W  = 7 * DIGITS;
  localparam int WORD_W = 4 * DIGITS;
  localparam int CNT_W  = $clog2(SETTLE_CYC + 1);
  localparam int BL_W   = $clog2(WORD_W + 1);

  logic [SEG_W-1:0]  seg_m, seg_s;
  logic              bp_m, bp_s, bp_d;
  logic [CNT_W-1:0]  cnt;
  logic              armed;
  logic              edge_det, sample_stb;
  logic [SEG_W-1:0]  lit;
  logic [WORD_W-1:0] nib_w, samp_word, sh_reg;
  logic [DIGITS-1:0] ok_w;
  logic              samp_valid, hold_valid, load;
  logic [BL_W-1:0]   bits_left;

  function automatic logic [4:0] dec7(input logic [6:0] p);
    case (p)
      7'h7E: return 5'h10;
      7'h30: return 5'h11;
      7'h6D: return 5'h12;
      7'h79: return 5'h13;
      7'h33: return 5'h14;
      7'h5B: return 5'h15;
      7'h5F: return 5'h16;
      7'h70: return 5'h17;
      7'h7F: return 5'h18;
      7'h7B: return 5'h19;
      default: return 5'h0F;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_m <= '0; seg_s <= '0;
      bp_m  <= 1'b0; bp_s <= 1'b0; bp_d <= 1'b0;
    end else begin
      seg_m <= seg_in; seg_s <= seg_m;
      bp_m  <= bp_in;  bp_s  <= bp_m; bp_d <= bp_s;
    end
  end

  assign edge_det   = bp_s ^ bp_d;
  assign sample_stb = armed && !edge_det && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (edge_det) begin
      cnt   <= CNT_W'(SETTLE_CYC);
      armed <= 1'b1;
    end else if (armed) begin
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) armed <= 1'b0;
    end
  end

  assign lit = seg_s ^ {SEG_W{bp_s}};

  for (genvar g = 0; g < DIGITS; g++) begin : g_dec
    logic [4:0] d;
    assign d             = dec7(lit[7*g +: 7]);
    assign nib_w[4*g +: 4] = d[3:0];
    assign ok_w[g]       = d[4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_word  <= '1;
      samp_valid <= 1'b0;
    end else if (sample_stb) begin
      samp_word  <= nib_w;
      samp_valid <= &ok_w;
    end
  end

  assign load = latch_req && (bits_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_reg     <= '0;
      hold_valid <= 1'b0;
      bits_left  <= '0;
    end else if (load) begin
      sh_reg     <= samp_word;
      hold_valid <= samp_valid;
      bits_left  <= BL_W'(WORD_W);
    end else if (shift_en) begin
      sh_reg <= {sh_reg[WORD_W-2:0], ser_in};
      if (bits_left != '0) bits_left <= bits_left - BL_W'(1);
    end
  end

  assign ser_out    = sh_reg[WORD_W-1];
  assign word_valid = hold_valid;
endmodule

// File: rtl/lcd_seg_capture_chk.sv
module lcd_seg_capture_chk #(
  parameter int WORD_W = 16,
  parameter int BL_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              edge_det,
  input logic              sample_stb,
  input logic [WORD_W-1:0] samp_word,
  input logic              samp_valid,
  input logic [WORD_W-1:0] sh_reg,
  input logic [BL_W-1:0]   bits_left,
  input logic              latch_req,
  input logic              shift_en,
  input logic              ser_in
);
  logic all_le9, any_f;
  always_comb begin
    all_le9 = 1'b1;
    any_f   = 1'b0;
    for (int i = 0; i < WORD_W/4; i++) begin
      if (samp_word[4*i +: 4] > 4'd9)  all_le9 = 1'b0;
      if (samp_word[4*i +: 4] == 4'hF) any_f   = 1'b1;
    end
  end

  assert_no_edge_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |-> !sample_stb);
  assert_word_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> ($stable(samp_word) && $stable(samp_valid)));
  assert_valid_digits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid |-> all_le9);
  assert_invalid_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_valid |-> any_f);
  assert_load_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_req && bits_left == '0) |=> sh_reg == $past(samp_word));
  assert_shift_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !(latch_req && bits_left == '0)) |=>
      sh_reg == {$past(sh_reg[WORD_W-2:0]), $past(ser_in)});
  assert_latch_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_req && bits_left != '0 && !shift_en) |=> $stable(sh_reg));
  assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bits_left <= BL_W'(WORD_W));
endmodule

bind lcd_seg_capture lcd_seg_capture_chk #(.WORD_W(WORD_W), .BL_W(BL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_det(edge_det), .sample_stb(sample_stb),
  .samp_word(samp_word), .samp_valid(samp_valid), .sh_reg(sh_reg),
  .bits_left(bits_left), .latch_req(latch_req), .shift_en(shift_en), .ser_in(ser_in)
);

// File: tb/sim_lcd_seg_capture.sv
`timescale 1ns/1ps
module sim_lcd_seg_capture;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [27:0] seg_in = '0;
  logic bp_in = 1'b0, latch_req = 1'b0, shift_en = 1'b0, ser_in = 1'b0;
  logic ser_out, word_valid;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  lcd_seg_capture u0 (.clk(clk), .rst_n(rst_n), .seg_in(seg_in), .bp_in(bp_in),
    .latch_req(latch_req), .shift_en(shift_en), .ser_in(ser_in),
    .ser_out(ser_out), .word_valid(word_valid));

  // Glyph codes: 0..9 numerals, A=letter A, B=P, C=H, D=E, E=L, F=blank
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{16'h1234, 16'h5678, 16'h9012, 16'h0000,
    16'h9999, 16'h3A47, 16'hBCDE, 16'h870F, 16'h6E59};

  function automatic logic [6:0] glyph(input logic [3:0] c);
    case (c)
      4'h0: return 7'h7E; 4'h1: return 7'h30; 4'h2: return 7'h6D; 4'h3: return 7'h79;
      4'h4: return 7'h33; 4'h5: return 7'h5B; 4'h6: return 7'h5F; 4'h7: return 7'h70;
      4'h8: return 7'h7F; 4'h9: return 7'h7B; 4'hA: return 7'h77; 4'hB: return 7'h67;
      4'hC: return 7'h37; 4'hD: return 7'h4F; 4'hE: return 7'h0E; default: return 7'h00;
    endcase
  endfunction

  function automatic logic [27:0] lit_of(input logic [15:0] code);
    logic [27:0] l;
    for (int d = 0; d < 4; d++) l[7*d +: 7] = glyph(code[4*d +: 4]);
    return l;
  endfunction

  function automatic logic [15:0] exp_word(input logic [15:0] code);
    logic [15:0] w;
    for (int d = 0; d < 4; d++) w[4*d +: 4] = (code[4*d +: 4] <= 4'd9) ? code[4*d +: 4] : 4'hF;
    return w;
  endfunction

  function automatic logic exp_valid(input logic [15:0] code);
    logic v = 1'b1;
    for (int d = 0; d < 4; d++) if (code[4*d +: 4] > 4'd9) v = 1'b0;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic bp, input logic [15:0] code);
    @(negedge clk);
    bp_in  = bp;
    seg_in = lit_of(code) ^ {28{bp}};
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] code);
    put(1'b0, code); hold(30);
    put(1'b1, code); hold(30);
  endtask

  task automatic read_word(output logic [15:0] w, output logic v);
    @(negedge clk); latch_req = 1'b1;
    @(negedge clk); latch_req = 1'b0;
    v = word_valid;
    shift_en = 1'b1;
    w[15] = ser_out;
    for (int i = 14; i >= 0; i--) begin
      @(negedge clk); w[i] = ser_out;
    end
    @(negedge clk); shift_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] w, pat;
    logic v;
    hold(3);
    check("R9 ser_out after reset", {31'd0, ser_out}, 32'd0);
    check("R9 word_valid after reset", {31'd0, word_valid}, 32'd0);
    rst_n = 1'b1;
    hold(2);
    read_word(w, v);
    check("R9 word before any sample", {16'd0, w}, 32'h0000FFFF);
    check("R9 valid before any sample", {31'd0, v}, 32'd0);

    // R3 R4 R5 R6 R7: table walk
    for (int k = 0; k < NV; k++) begin
      frame(VEC[k]);
      read_word(w, v);
      check("R3/R4/R5 decoded word", {16'd0, w}, {16'd0, exp_word(VEC[k])});
      check("R4/R6 word_valid", {31'd0, v}, {31'd0, exp_valid(VEC[k])});
    end

    // R1: sample taken in the low backplane phase
    put(1'b0, 16'h4321); hold(30);
    read_word(w, v);
    check("R1 low-phase decode", {16'd0, w}, 32'h00004321);
    put(1'b1, 16'h8765); hold(30);
    read_word(w, v);
    check("R1 high-phase decode", {16'd0, w}, 32'h00008765);

    // R2: latch soon after an edge returns the earlier word, later the new one
    put(1'b0, 16'h2468); hold(3);
    read_word(w, v);
    check("R2 early latch keeps old word", {16'd0, w}, 32'h00008765);
    hold(30);
    read_word(w, v);
    check("R2 new word after settle", {16'd0, w}, 32'h00002468);
    // R2: pattern change without a backplane edge is not captured
    put(1'b0, 16'h1357); hold(40);
    read_word(w, v);
    check("R2 no edge no capture", {16'd0, w}, 32'h00002468);

    // R8: latch during an incomplete shift is ignored
    frame(16'h1234);
    @(negedge clk); latch_req = 1'b1;
    @(negedge clk); latch_req = 1'b0; shift_en = 1'b1;
    w[15] = ser_out;
    for (int i = 14; i >= 12; i--) begin @(negedge clk); w[i] = ser_out; end
    @(negedge clk); shift_en = 1'b0;
    frame(16'h5678);
    @(negedge clk); latch_req = 1'b1;
    @(negedge clk); latch_req = 1'b0; shift_en = 1'b1;
    w[11] = ser_out;
    for (int i = 10; i >= 0; i--) begin @(negedge clk); w[i] = ser_out; end
    @(negedge clk); shift_en = 1'b0;
    check("R8 blocked latch keeps old word", {16'd0, w}, 32'h00001234);
    read_word(w, v);
    check("R8 latch accepted after shift", {16'd0, w}, 32'h00005678);

    // R7: ser_in chains through the register, MSB first
    pat = 16'hA5C3;
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk); shift_en = 1'b1; ser_in = pat[i];
    end
    @(negedge clk); ser_in = 1'b0;
    w[15] = ser_out;
    for (int i = 14; i >= 0; i--) begin @(negedge clk); w[i] = ser_out; end
    @(negedge clk); shift_en = 1'b0;
    check("R7 serial chain data", {16'd0, w}, {16'd0, pat});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule